// File: doc/BRIEF.md
# UART Software Flow Control Unit

This block sits beside the receiver and transmitter of one UART channel and
carries out in-band pause and resume. Software programs two resume characters
and two pause characters, plus a feature register that turns matching on and
picks single-character or two-character matching. Every character the receiver
finishes is compared against the programmed values. A pause match stops the
transmitter once the character it is shifting has gone out. A resume match lets
it run again. Characters that complete a match are kept out of the receive
FIFO, and a sticky status flag reports that a programmed character arrived.

The unit also holds the interrupt-enable, FIFO-control, modem-control and
line-control registers, because several of their bits belong to this function.
One modem-control bit selects a mode in which any received character resumes
transmission. The upper interrupt-enable bits and two FIFO-control bits can only
be written while the enhanced-feature bit is set. A line-control bit forces the
serial output pin low (break) without touching the serialiser's own state.

Top module: `uart_swflow`

## Requirements
- R1: After reset `tx_go` is 1, `spc_flag` is 0, all register outputs are 0, and all four character registers hold 0x00 (with matching enabled, a received 0x00 is taken as a pause character).
- R2: A pause match sets an internal stop state one clock after the strobe; `tx_go` follows that state only on a clock edge where `tx_idle` is 1 and holds its value while `tx_idle` is 0.
- R3: In single mode (`feat_o[0]`=0), a received character equal to resume character 1 (address 5) clears the stop state; equal to pause character 1 (address 7) sets it; pause wins if both match.
- R4: `rx_we` equals `rx_valid` except for a character that completes a pause or resume match, for which `rx_we` stays 0.
- R5: In pair mode (`feat_o[0]`=1) a pause needs pause character 1 immediately followed by pause character 2 (address 8), and a resume needs resume character 1 followed by resume character 2 (address 6); only the second character is withheld, and any other character in between breaks the pair.
- R6: With `mcr_o[5]`=1, any received character that is not a pause match clears the stop state.
- R7: `spc_flag` is set one clock after a strobe whose data equals any of the four character registers while matching is enabled, and clears one clock after `stat_rd` when no new match arrives.
- R8: While `feat_o[4]`=0, writes to address 0 leave `ien_o[7:4]` unchanged and writes to address 1 leave `fcr_o[5:4]` unchanged; while it is 1 all bits are written.
- R9: `mcr_o[6]` always reads 0, whatever is written to address 2.
- R10: While `lcr_o[6]`=1, `txd_o` is 0; otherwise `txd_o` equals `txd_ser`; break has no effect on `tx_go`.
- R11: With matching disabled (`feat_o[1]`=0), the stop state is cleared, every strobe gives `rx_we`, and `spc_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0 ien, 1 fcr, 2 mcr, 3 lcr, 4 feat, 5 resume1, 6 resume2, 7 pause1, 8 pause2 |
| wr_data | input | 8 | Register write data |
| rx_valid | input | 1 | Receiver finished a character this cycle |
| rx_data | input | 8 | Received character, bit 0 is the first data bit |
| stat_rd | input | 1 | Status read pulse, clears `spc_flag` |
| tx_idle | input | 1 | Serialiser is between characters |
| txd_ser | input | 1 | Serial data from the serialiser |
| rx_we | output | 1 | Write the received character into the receive FIFO |
| tx_go | output | 1 | Transmitter may start a new character |
| spc_flag | output | 1 | Programmed character detected (status bit 4) |
| txd_o | output | 1 | Serial output pin |
| ien_o | output | 8 | Interrupt-enable register |
| fcr_o | output | 8 | FIFO-control register |
| mcr_o | output | 8 | Modem-control register, bit 5 resume-on-any |
| lcr_o | output | 8 | Line-control register, bit 6 break |
| feat_o | output | 8 | Feature register: bit 0 pair mode, bit 1 matching on, bit 4 enhanced write enable |

## Verification
The assertions assume one register write and at most one received character per
cycle, that `rx_data` is only meaningful while `rx_valid` is high, and that
`tx_idle` reflects the serialiser truthfully so a held `tx_go` is the right
answer while it is low. The stimulus drives every input on the falling edge,
issues writes and characters one per cycle, and holds `tx_idle` high except in
the deliberate busy window, so every input stays within those assumptions while
all 256 character values and all 256 register write values are swept.

// File: rtl/uart_swflow.sv
module uart_swflow (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       stat_rd,
  input  logic       tx_idle,
  input  logic       txd_ser,
  output logic       rx_we,
  output logic       tx_go,
  output logic       spc_flag,
  output logic       txd_o,
  output logic [7:0] ien_o,
  output logic [7:0] fcr_o,
  output logic [7:0] mcr_o,
  output logic [7:0] lcr_o,
  output logic [7:0] feat_o
);
  localparam logic [3:0] A_IEN = 4'd0, A_FCR = 4'd1, A_MCR = 4'd2, A_LCR = 4'd3,
                         A_FEAT = 4'd4, A_ON1 = 4'd5, A_ON2 = 4'd6,
                         A_OFF1 = 4'd7, A_OFF2 = 4'd8;
  localparam logic [7:0] IEN_LOCK = 8'hF0;
  localparam logic [7:0] FCR_LOCK = 8'h30;
  localparam logic [7:0] MCR_ZERO = 8'h40;

  logic [7:0] on1, on2, off1, off2;
  logic       flow_stop, stop_nxt, pend_on, pend_off;

  wire enh  = feat_o[4];
  wire chk  = feat_o[1];
  wire pair = feat_o[0];

  wire hit_on1  = rx_data == on1;
  wire hit_on2  = rx_data == on2;
  wire hit_off1 = rx_data == off1;
  wire hit_off2 = rx_data == off2;

  wire match_off = pair ? (pend_off && hit_off2) : hit_off1;
  wire match_on  = pair ? (pend_on  && hit_on2)  : hit_on1;
  wire flow_hit  = rx_valid && chk && (match_off || match_on);
  wire spc_hit   = rx_valid && chk && (hit_on1 || hit_on2 || hit_off1 || hit_off2);

  assign rx_we = rx_valid && !flow_hit;
  assign txd_o = lcr_o[6] ? 1'b0 : txd_ser;

  always_comb begin
    stop_nxt = flow_stop;
    if (!chk)
      stop_nxt = 1'b0;
    else if (rx_valid) begin
      if (match_off)
        stop_nxt = 1'b1;
      else if (match_on || mcr_o[5])
        stop_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_o <= '0; fcr_o <= '0; mcr_o <= '0; lcr_o <= '0; feat_o <= '0;
      on1 <= '0; on2 <= '0; off1 <= '0; off2 <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_IEN:  ien_o  <= enh ? wr_data : (ien_o & IEN_LOCK) | (wr_data & ~IEN_LOCK);
        A_FCR:  fcr_o  <= enh ? wr_data : (fcr_o & FCR_LOCK) | (wr_data & ~FCR_LOCK);
        A_MCR:  mcr_o  <= wr_data & ~MCR_ZERO;
        A_LCR:  lcr_o  <= wr_data;
        A_FEAT: feat_o <= wr_data;
        A_ON1:  on1    <= wr_data;
        A_ON2:  on2    <= wr_data;
        A_OFF1: off1   <= wr_data;
        A_OFF2: off2   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_stop <= 1'b0;
      tx_go     <= 1'b1;
      pend_on   <= 1'b0;
      pend_off  <= 1'b0;
      spc_flag  <= 1'b0;
    end else begin
      flow_stop <= stop_nxt;
      if (tx_idle)
        tx_go <= !flow_stop;
      if (!chk) begin
        pend_on  <= 1'b0;
        pend_off <= 1'b0;
      end else if (rx_valid) begin
        pend_on  <= pair && hit_on1;
        pend_off <= pair && hit_off1;
      end
      if (spc_hit)
        spc_flag <= 1'b1;
      else if (stat_rd)
        spc_flag <= 1'b0;
    end
  end
endmodule

module uart_swflow_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_we,
  input logic       tx_idle,
  input logic       tx_go,
  input logic       stat_rd,
  input logic       spc_flag,
  input logic       txd_o,
  input logic [7:0] ien_o,
  input logic [7:0] fcr_o,
  input logic [7:0] mcr_o,
  input logic [7:0] lcr_o,
  input logic [7:0] feat_o
);
  a_r2_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> $stable(tx_go));
  a_r4_store_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> rx_valid);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    spc_flag && !stat_rd |=> spc_flag);
  a_r8_ien_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_o[4] |=> $stable(ien_o[7:4]));
  a_r8_fcr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_o[4] |=> $stable(fcr_o[5:4]));
  a_r9_mcr6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_o[6]);
  a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_o[6] |-> !txd_o);
  a_r11_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !feat_o[1] |-> rx_we);
endmodule

bind uart_swflow uart_swflow_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_we(rx_we),
  .tx_idle(tx_idle), .tx_go(tx_go), .stat_rd(stat_rd), .spc_flag(spc_flag),
  .txd_o(txd_o), .ien_o(ien_o), .fcr_o(fcr_o), .mcr_o(mcr_o),
  .lcr_o(lcr_o), .feat_o(feat_o)
);

// File: tb/test_uart_swflow.sv
module test_uart_swflow;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       stat_rd = 1'b0;
  logic       tx_idle = 1'b1;
  logic       txd_ser = 1'b1;
  logic       rx_we, tx_go, spc_flag, txd_o;
  logic [7:0] ien_o, fcr_o, mcr_o, lcr_o, feat_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  uart_swflow i_uart_swflow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .stat_rd(stat_rd), .tx_idle(tx_idle),
    .txd_ser(txd_ser), .rx_we(rx_we), .tx_go(tx_go), .spc_flag(spc_flag),
    .txd_o(txd_o), .ien_o(ien_o), .fcr_o(fcr_o), .mcr_o(mcr_o), .lcr_o(lcr_o),
    .feat_o(feat_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rx(input logic [7:0] d, output logic we);
    rx_valid = 1'b1; rx_data = d;
    #1 we = rx_we;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clr_spc;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic we;
    bit   stop;
    logic [7:0] ien_exp;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    check("R1 tx_go", tx_go, 1);
    check("R1 spc_flag", spc_flag, 0);
    check("R1 ien", ien_o, 0);
    check("R1 fcr", fcr_o, 0);
    check("R1 mcr", mcr_o, 0);
    check("R1 lcr", lcr_o, 0);
    check("R1 feat", feat_o, 0);
    check("R1 txd", txd_o, 1);

    // R1: cleared character registers make 0x00 a pause character
    wr(4'd4, 8'h02);
    rx(8'h00, we);
    check("R1 zero char withheld", we, 0);
    cyc(1);
    check("R1 zero char pauses", tx_go, 0);
    check("R7 zero char flag", spc_flag, 1);
    wr(4'd4, 8'h00);
    cyc(2);
    check("R11 disable clears stop", tx_go, 1);
    clr_spc();
    check("R7 flag cleared", spc_flag, 0);

    wr(4'd5, 8'h11); wr(4'd6, 8'h21); wr(4'd7, 8'h13); wr(4'd8, 8'h23);
    wr(4'd4, 8'h02);

    // R3 R4 R7: every character value in single mode
    stop = 1'b0;
    for (int d = 0; d < 256; d++) begin
      bit is_flow, is_spc;
      is_flow = (d == 8'h11) || (d == 8'h13);
      is_spc  = is_flow || (d == 8'h21) || (d == 8'h23);
      if (d == 8'h13) stop = 1'b1;
      else if (d == 8'h11) stop = 1'b0;
      rx(8'(d), we);
      check("R4 sweep rx_we", we, !is_flow);
      cyc(1);
      check("R3 sweep tx_go", tx_go, !stop);
      check("R7 sweep spc_flag", spc_flag, is_spc);
      if (spc_flag) clr_spc();
    end
    if (stop) begin rx(8'h11, we); cyc(1); end

    // R2: pause while the serialiser is busy
    tx_idle = 1'b0;
    rx(8'h13, we);
    cyc(3);
    check("R2 held while busy", tx_go, 1);
    tx_idle = 1'b1;
    cyc(1);
    check("R2 pause at boundary", tx_go, 0);
    rx(8'h11, we);
    cyc(1);
    check("R3 resume", tx_go, 1);

    // R6: resume on any character
    wr(4'd2, 8'h20);
    rx(8'h13, we);
    cyc(1);
    check("R6 paused", tx_go, 0);
    rx(8'h41, we);
    check("R6 plain char stored", we, 1);
    cyc(1);
    check("R6 any char resumes", tx_go, 1);
    wr(4'd2, 8'h00);

    // R5: pair mode
    wr(4'd4, 8'h03);
    rx(8'h23, we);
    check("R5 lone second stored", we, 1);
    cyc(1);
    check("R5 lone second no pause", tx_go, 1);
    rx(8'h13, we);
    check("R5 first of pair stored", we, 1);
    rx(8'h23, we);
    check("R5 second of pair withheld", we, 0);
    cyc(1);
    check("R5 pair pauses", tx_go, 0);
    rx(8'h11, we);
    rx(8'h21, we);
    check("R5 resume pair withheld", we, 0);
    cyc(1);
    check("R5 pair resumes", tx_go, 1);
    rx(8'h13, we);
    rx(8'h41, we);
    rx(8'h23, we);
    check("R5 broken pair stored", we, 1);
    cyc(1);
    check("R5 broken pair no pause", tx_go, 1);
    clr_spc();

    // R11: matching off
    wr(4'd4, 8'h00);
    rx(8'h13, we);
    check("R11 stored when off", we, 1);
    cyc(1);
    check("R11 no pause when off", tx_go, 1);
    check("R11 no flag when off", spc_flag, 0);

    // R8 R9: register write sweep with enhanced writes locked
    for (int v = 0; v < 256; v++) begin
      wr(4'd0, 8'(v));
      wr(4'd1, 8'(v));
      wr(4'd2, 8'(v));
      check("R8 ien locked", ien_o, v & 8'h0F);
      check("R8 fcr locked", fcr_o, v & 8'hCF);
      check("R9 mcr6 zero", mcr_o, v & 8'hBF);
    end
    wr(4'd4, 8'h10);
    wr(4'd0, 8'hA5);
    wr(4'd1, 8'hFF);
    check("R8 ien open", ien_o, 8'hA5);
    check("R8 fcr open", fcr_o, 8'hFF);
    wr(4'd4, 8'h00);
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h00);
    ien_exp = 8'hA0;
    check("R8 ien upper kept", ien_o, ien_exp);
    check("R8 fcr bits kept", fcr_o, 8'h30);
    wr(4'd2, 8'h00);

    // R10: break
    wr(4'd3, 8'h40);
    txd_ser = 1'b1; #1;
    check("R10 break forces low", txd_o, 0);
    check("R10 tx_go untouched", tx_go, 1);
    wr(4'd3, 8'h00);
    #1 check("R10 release high", txd_o, 1);
    txd_ser = 1'b0; #1;
    check("R10 follows serialiser", txd_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule